// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block turns a master-clock strobe (`mclk_tick`, one pulse per master-clock period, synchronous to the system clock) into two audio serial clocks. The first is a bit clock (`sclk`) at one half or one quarter of the master rate. The second is a frame clock (`lrclk`) at 1/32, 1/64 or 1/128 of the bit rate. Both clocks are produced as registered levels in the system clock domain. Each `sclk` transition comes with a one-cycle strobe, and each new frame comes with a one-cycle frame strobe, so that a serialiser placed beside the block can act on edges without detecting them itself.

Settings come from a 32-bit configuration word. The fields that set the clock ratios and the edge polarity can come either from that word or from a 4-bit configuration supplied by a neighbouring audio block. A local-override bit in the word makes the choice. The run enable always comes from the configuration word.

Two small state machines do the work. The bit-clock machine has the states `SD_OFF`, `SD_LOW` and `SD_HIGH`:
- `SD_OFF` goes to `SD_LOW` when enable is set and no toggle is due.
- `SD_OFF` or `SD_LOW` goes to `SD_HIGH` on a rising toggle.
- `SD_HIGH` goes to `SD_LOW` on a falling toggle.
- Any state goes to `SD_OFF` when enable is clear.

The frame machine has the states `FS_IDLE`, `FS_LOW`, `FS_HIGH` and `FS_NOFRAME`:
- `FS_IDLE` or `FS_NOFRAME` goes to `FS_LOW` on start.
- `FS_LOW` goes to `FS_HIGH` at the half-frame point.
- `FS_HIGH` goes to `FS_LOW` when the frame wraps, which also raises the frame strobe.
- Any state goes to `FS_NOFRAME` when the frame code is invalid.
- Any state goes to `FS_IDLE` when enable is clear.

Top module: `audio_bitclk_gen`

## Requirements
- R1: The bit-clock ratio select is `cfg_word[16]`. A value of 0 makes `sclk` toggle on every accepted `mclk_tick`, giving master/2. A value of 1 makes it toggle on every second accepted tick, giving master/4. After enable the first toggle is a rising one.
- R2: The frame code is `cfg_word[18:17]`. Codes 0, 1 and 2 give a frame of 32, 64 or 128 active bit-clock edges. `lrclk` is low for the first half of each frame and high for the second half.
- R3: Frame code 3 is invalid. While it applies, `lrclk` stays 0 and `frame_stb` never pulses, but `sclk` keeps running.
- R4: The enable is `cfg_word[31]`. While it is clear, `sclk`, `lrclk` and all strobes are 0 from the next clock edge on, and `mclk_tick` is ignored.
- R5: The polarity bit is `cfg_word[19]`. When it is 1, `lrclk` changes only in the cycle in which `sclk` falls. When it is 0, `lrclk` changes only in the cycle in which `sclk` rises.
- R6: The local-override bit is `cfg_word[29]`. When it is 1, the ratio select, frame code and polarity are taken from `cfg_word`. When it is 0, they are taken from `ext_cfg`, where bit 0 is the ratio select, bits 2:1 are the frame code and bit 3 is the polarity.
- R7: `sclk_rise_stb` and `sclk_fall_stb` are high for exactly the one cycle in which `sclk` has just risen or fallen. The two are never high together.
- R8: `frame_stb` is high for one cycle exactly when `lrclk` has just fallen from high to low, which marks the start of a new frame.
- R9: A rising enable restarts both dividers from zero. The first `sclk` rise follows the first full half-period of ticks, and the first frame has its full length.
- R10: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk_tick | input | 1 | One pulse per master-clock period |
| cfg_word | input | 32 | Configuration word (fields listed in R1 to R6) |
| ext_cfg | input | 4 | Ratio, frame code and polarity from the neighbouring audio block |
| sclk | output | 1 | Bit clock level |
| lrclk | output | 1 | Frame clock level |
| sclk_rise_stb | output | 1 | One-cycle pulse after an `sclk` rise |
| sclk_fall_stb | output | 1 | One-cycle pulse after an `sclk` fall |
| frame_stb | output | 1 | One-cycle pulse at the start of each frame |

## Verification
The frame machine's half-frame transition and the bit-clock toggle fall in the same system cycle, because `lrclk` must move on the very edge at which `sclk` moves. The end of a frame also coincides with the frame strobe and with an `sclk` strobe. The bench sweeps every ratio, frame code and polarity, with tick spacings of one to three cycles. After each cycle it compares all five outputs against a tick-count model: toggles are ticks divided by the half period, and the frame level is active edges divided by the half frame. The check that an `lrclk` change and the matching `sclk` strobe occur in the same cycle therefore confirms that the two machines share that edge.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;

    // Configuration word field positions (decoded by neighbouring logic)
    localparam int CFG_SDIV_BIT   = 16;
    localparam int CFG_FRAME_LSB  = 17;
    localparam int CFG_POL_BIT    = 19;
    localparam int CFG_LOCAL_BIT  = 29;
    localparam int CFG_EN_BIT     = 31;

    typedef struct packed {
        logic       edge_pol;    // 1: frame clock moves on falling bit-clock edge
        logic [1:0] frame_code;  // 0..2 valid, 3 invalid
        logic       sdiv_sel;    // 0: master/2, 1: master/4
    } clk_cfg_t;

    typedef enum logic [1:0] {
        SD_OFF,
        SD_LOW,
        SD_HIGH
    } sclk_state_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_LOW,
        FS_HIGH,
        FS_NOFRAME
    } frame_state_e;

endpackage

// File: rtl/acg_cfg_select.sv
module acg_cfg_select
    import audio_clk_pkg::*;
(
    input  logic [31:0] cfg_word,
    input  logic [3:0]  ext_cfg,
    output clk_cfg_t    eff_cfg,
    output logic        run_en
);

    clk_cfg_t local_cfg;
    clk_cfg_t remote_cfg;
    logic     unused_cfg_bits;

    always_comb begin
        local_cfg.sdiv_sel   = cfg_word[CFG_SDIV_BIT];
        local_cfg.frame_code = cfg_word[CFG_FRAME_LSB +: 2];
        local_cfg.edge_pol   = cfg_word[CFG_POL_BIT];
        remote_cfg.sdiv_sel   = ext_cfg[0];
        remote_cfg.frame_code = ext_cfg[2:1];
        remote_cfg.edge_pol   = ext_cfg[3];
    end

    assign eff_cfg = cfg_word[CFG_LOCAL_BIT] ? local_cfg : remote_cfg;
    assign run_en  = cfg_word[CFG_EN_BIT];

    assign unused_cfg_bits = ^{cfg_word[30], cfg_word[28:20], cfg_word[15:0]};

endmodule

// File: rtl/acg_sclk_div.sv
module acg_sclk_div
    import audio_clk_pkg::*;
#(
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic mclk_tick,
    input  logic sdiv_sel,
    output logic rise_now,
    output logic fall_now,
    output logic sclk_o,
    output logic rise_stb_o,
    output logic fall_stb_o
);

    localparam int HALF_FAST = DIV_FAST / 2;
    localparam int HALF_SLOW = DIV_SLOW / 2;
    localparam int HALF_MAX  = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
    localparam int PW        = $clog2(HALF_MAX + 1);

    sclk_state_e    state_q, state_d;
    logic [PW-1:0]  pre_q, pre_d;
    logic [PW-1:0]  half_m1;
    logic           at_end;
    logic           toggle_now;

    assign half_m1    = sdiv_sel ? PW'(HALF_SLOW - 1) : PW'(HALF_FAST - 1);
    assign at_end     = (pre_q >= half_m1);
    assign toggle_now = run_en && mclk_tick && at_end;
    assign rise_now   = toggle_now && (state_q != SD_HIGH);
    assign fall_now   = toggle_now && (state_q == SD_HIGH);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SD_OFF:  state_d = !run_en ? SD_OFF  : (rise_now ? SD_HIGH : SD_LOW);
            SD_LOW:  state_d = !run_en ? SD_OFF  : (rise_now ? SD_HIGH : SD_LOW);
            SD_HIGH: state_d = !run_en ? SD_OFF  : (fall_now ? SD_LOW  : SD_HIGH);
            default: state_d = SD_OFF;
        endcase
    end

    always_comb begin
        pre_d = pre_q;
        if (!run_en)
            pre_d = '0;
        else if (mclk_tick)
            pre_d = at_end ? '0 : pre_q + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SD_OFF;
            pre_q   <= '0;
        end else begin
            state_q <= state_d;
            pre_q   <= pre_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_o     <= 1'b0;
            rise_stb_o <= 1'b0;
            fall_stb_o <= 1'b0;
        end else begin
            sclk_o     <= (state_d == SD_HIGH);
            rise_stb_o <= rise_now;
            fall_stb_o <= fall_now;
        end
    end

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb_o && fall_stb_o));

    assert_prescale_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q < PW'(HALF_MAX)));

endmodule

// File: rtl/acg_frame_fsm.sv
module acg_frame_fsm
    import audio_clk_pkg::*;
#(
    parameter int FRAME_BASE = 32,
    parameter int NUM_RATIOS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       act_edge,
    input  logic [1:0] frame_code,
    output logic       lrclk_o,
    output logic       frame_stb_o
);

    localparam int HALF_BASE = FRAME_BASE / 2;
    localparam int HALF_MAX  = HALF_BASE << (NUM_RATIOS - 1);
    localparam int CW        = $clog2(HALF_MAX) + 1;

    frame_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] half_m1;
    logic          code_ok;
    logic          at_half;
    logic          wrap_now;

    assign code_ok  = (int'(frame_code) < NUM_RATIOS);
    assign half_m1  = CW'((HALF_BASE << frame_code) - 1);
    assign at_half  = act_edge && (cnt_q >= half_m1);
    assign wrap_now = run_en && code_ok && (state_q == FS_HIGH) && at_half;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!run_en) begin
            state_d = FS_IDLE;
            cnt_d   = '0;
        end else if (!code_ok) begin
            state_d = FS_NOFRAME;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                FS_IDLE, FS_NOFRAME: begin
                    state_d = FS_LOW;
                    cnt_d   = act_edge ? CW'(1) : '0;
                end
                FS_LOW: begin
                    if (at_half) begin
                        state_d = FS_HIGH;
                        cnt_d   = '0;
                    end else if (act_edge) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                FS_HIGH: begin
                    if (at_half) begin
                        state_d = FS_LOW;
                        cnt_d   = '0;
                    end else if (act_edge) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = FS_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lrclk_o     <= 1'b0;
            frame_stb_o <= 1'b0;
        end else begin
            lrclk_o     <= (state_d == FS_HIGH);
            frame_stb_o <= wrap_now;
        end
    end

    assert_frame_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb_o |-> (!lrclk_o && $past(lrclk_o)));

    assert_no_frame_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb_o |-> $past(code_ok));

endmodule

// File: rtl/audio_bitclk_gen.sv
module audio_bitclk_gen
    import audio_clk_pkg::*;
#(
    parameter int DIV_FAST   = 2,
    parameter int DIV_SLOW   = 4,
    parameter int FRAME_BASE = 32,
    parameter int NUM_RATIOS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mclk_tick,
    input  logic [31:0] cfg_word,
    input  logic [3:0]  ext_cfg,
    output logic        sclk,
    output logic        lrclk,
    output logic        sclk_rise_stb,
    output logic        sclk_fall_stb,
    output logic        frame_stb
);

    clk_cfg_t eff_cfg;
    logic     run_en;
    logic     rise_now;
    logic     fall_now;
    logic     act_edge;
    logic     frame_ok;

    acg_cfg_select u_cfg (
        .cfg_word (cfg_word),
        .ext_cfg  (ext_cfg),
        .eff_cfg  (eff_cfg),
        .run_en   (run_en)
    );

    acg_sclk_div #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_sdiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .mclk_tick  (mclk_tick),
        .sdiv_sel   (eff_cfg.sdiv_sel),
        .rise_now   (rise_now),
        .fall_now   (fall_now),
        .sclk_o     (sclk),
        .rise_stb_o (sclk_rise_stb),
        .fall_stb_o (sclk_fall_stb)
    );

    assign act_edge = eff_cfg.edge_pol ? fall_now : rise_now;
    assign frame_ok = (int'(eff_cfg.frame_code) < NUM_RATIOS);

    acg_frame_fsm #(
        .FRAME_BASE (FRAME_BASE),
        .NUM_RATIOS (NUM_RATIOS)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .act_edge    (act_edge),
        .frame_code  (eff_cfg.frame_code),
        .lrclk_o     (lrclk),
        .frame_stb_o (frame_stb)
    );

    assert_idle_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!sclk && !lrclk && !frame_stb && !sclk_rise_stb && !sclk_fall_stb));

    assert_rise_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise_stb |-> (sclk && !$past(sclk)));

    assert_fall_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall_stb |-> (!sclk && $past(sclk)));

    assert_lrclk_edge_pol_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((lrclk != $past(lrclk)) && $past(run_en) && $past(frame_ok))
        |-> ($past(eff_cfg.edge_pol) ? sclk_fall_stb : sclk_rise_stb));

    assert_invalid_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !frame_ok) |=> (!lrclk && !frame_stb));

endmodule

// File: tb/audio_bitclk_gen_tb_top.sv
module audio_bitclk_gen_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mclk_tick = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [3:0]  ext_cfg = '0;
    logic        sclk, lrclk, sclk_rise_stb, sclk_fall_stb, frame_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    audio_bitclk_gen dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mclk_tick     (mclk_tick),
        .cfg_word      (cfg_word),
        .ext_cfg       (ext_cfg),
        .sclk          (sclk),
        .lrclk         (lrclk),
        .sclk_rise_stb (sclk_rise_stb),
        .sclk_fall_stb (sclk_fall_stb),
        .frame_stb     (frame_stb)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] make_word(bit en, bit ovr, bit sdiv, int code, bit pol);
        logic [31:0] w;
        w = '0;
        w[31]    = en;
        w[29]    = ovr;
        w[19]    = pol;
        w[18:17] = code[1:0];
        w[16]    = sdiv;
        return w;
    endfunction

    task automatic run_case(bit sdiv, int code, bit pol, bit ovr, int p);
        int h, half, ncyc, n, t, prev_t, a, prev_a;
        int first_rise_ticks;
        bit valid, exp_rise, exp_fall, exp_fs;
        string rs, rl;
        h     = sdiv ? 2 : 1;
        half  = 16 << code;
        valid = (code < 3);
        ncyc  = 4 * (valid ? half : 16) * 2 * h * p + 8;
        rs    = ovr ? "R1" : "R6";
        rl    = !valid ? "R3" : (pol ? "R5" : "R2");

        // disabled phase: ticks keep coming but must be ignored (R4)
        cfg_word = make_word(1'b0, ovr, sdiv, code, pol);
        mclk_tick = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R4", "sclk off", sclk, 0);
            chk("R4", "lrclk off", lrclk, 0);
            chk("R4", "strobes off", {sclk_rise_stb, sclk_fall_stb, frame_stb}, 0);
        end

        // configure source: real fields on the selected side, junk on the other
        if (ovr) begin
            cfg_word = make_word(1'b1, 1'b1, sdiv, code, pol);
            ext_cfg  = ~{pol, code[1:0], sdiv};
        end else begin
            cfg_word = make_word(1'b1, 1'b0, !sdiv, (code == 0) ? 3 : 0, !pol);
            ext_cfg  = {pol, code[1:0], sdiv};
        end

        n = 0; prev_t = 0; prev_a = 0; first_rise_ticks = -1;
        for (int c = 0; c < ncyc; c++) begin
            mclk_tick = ((c % p) == 0);
            @(posedge clk);
            if (mclk_tick) n++;
            @(negedge clk);
            t        = n / h;
            exp_rise = (t != prev_t) && (t % 2 == 1);
            exp_fall = (t != prev_t) && (t % 2 == 0);
            a        = pol ? (t / 2) : ((t + 1) / 2);
            exp_fs   = valid && (a != prev_a) && (a % (2 * half) == 0);
            chk(rs, "sclk", sclk, t % 2);
            chk("R7", "rise strobe", sclk_rise_stb, exp_rise);
            chk("R7", "fall strobe", sclk_fall_stb, exp_fall);
            chk(rl, "lrclk", lrclk, valid ? ((a / half) % 2) : 0);
            chk(valid ? "R8" : "R3", "frame strobe", frame_stb, exp_fs);
            if (sclk_rise_stb && first_rise_ticks < 0) first_rise_ticks = n;
            prev_t = t;
            prev_a = a;
        end
        chk("R9", "ticks to first rise", first_rise_ticks, h);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mclk_tick = 1'b1;
        cfg_word  = make_word(1'b1, 1'b1, 1'b0, 0, 1'b0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10", "sclk in reset", sclk, 0);
        chk("R10", "lrclk in reset", lrclk, 0);
        chk("R10", "strobes in reset", {sclk_rise_stb, sclk_fall_stb, frame_stb}, 0);
        cfg_word = '0;
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10", "outputs after reset", {sclk, lrclk, sclk_rise_stb, sclk_fall_stb, frame_stb}, 0);

        for (int sd = 0; sd < 2; sd++)
            for (int code = 0; code < 4; code++)
                for (int pol = 0; pol < 2; pol++)
                    run_case(sd[0], code, pol[0], 1'b1, 1 + ((sd + code + pol) % 3));

        run_case(1'b0, 1, 1'b1, 1'b0, 1);
        run_case(1'b1, 0, 1'b0, 1'b0, 2);
        run_case(1'b0, 3, 1'b0, 1'b0, 1);
        run_case(1'b1, 2, 1'b1, 1'b0, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule